// File: doc/BRIEF.md
# SM3 Two-Round Compression Unit

This unit advances an SM3 hash state by two consecutive compression rounds. The caller supplies three 128-bit operands and a 6-bit round selector. One operand carries the working words A, B, E and F. Another carries C, D, G and H as they come out of the previous step, before their rotations; the unit rotates them when it takes them in. The third operand carries the four message words the two rounds need. The unit works out the round constant, its per-round rotation and the boolean functions, which change at round 16. It returns the new A, B, E and F packed into one 128-bit word.

A hash engine calls the unit 32 times per 64-round block and feeds each result back as the next call's A/B/E/F operand. The engine rotates and supplies the C/D/G/H words and the message words. Message expansion, padding and the final chaining XOR are not part of this unit.

The `TWO_CYCLE` parameter chooses between two builds. With `TWO_CYCLE = 0`, both rounds are computed in one cycle. With `TWO_CYCLE = 1`, one round is computed per cycle, which shortens the logic path to a single round. Both builds use the same start/done handshake.

Top module: `sm3_dual_round`

## Requirements
- R1: While `rst_n` is low, `done` is 0 and `result` is all zeros.
- R2: Bit 0 of `round_sel` is ignored. The first round number is j = `round_sel` & 6'h3E, and the second round number is j+1. A selector of 31 gives the same result as 30, and 63 gives the same result as 62.
- R3: Lanes are 32 bits wide, with lane k at bits [32k+31:32k]. On entry the words are taken as follows:
  - A = `opnd_b` lane 3, B = lane 2, E = lane 1, F = lane 0.
  - C = rotl(`opnd_a` lane 3, 9) and D = rotl(`opnd_a` lane 2, 9).
  - G = rotl(`opnd_a` lane 1, 19) and H = rotl(`opnd_a` lane 0, 19).
- R4: For round numbers below 16 the constant is 32'h79CC4519. From round 16 on it is 32'h7A879D8A. In each round the constant is rotated left by that round's number modulo 32.
- R5: Below round 16, both boolean functions are the three-way XOR. From round 16 on, the A-side function is majority and the E-side function is (x&y)|(~x&z).
- R6: Each round computes SS1 = rotl(rotl(A,12)+E+Tr, 7) and SS2 = SS1 ^ rotl(A,12).
  - Round i (i = 0 or 1) uses message word `opnd_c` lane i, and the XOR of `opnd_c` lanes i and i+2 as W'.
  - TT1 = FF + D + SS2 + W' and TT2 = GG + H + SS1 + W. All additions are modulo 2^32.
  - The state then moves as: D←C, C←rotl(B,9), B←A, A←TT1, H←G, G←rotl(F,19), F←E, E←P0(TT2), where P0(x) = x^rotl(x,9)^rotl(x,17).
- R7: `result` carries F in lane 0, E in lane 1, B in lane 2 and A in lane 3.
- R8: With `TWO_CYCLE = 0`, a `start` sampled high at a clock edge sets `done` high and loads `result` at that same edge. A `start` in every cycle gives back-to-back results.
- R9: With `TWO_CYCLE = 1`, `done` rises at the second edge after the accepted `start`. The operands and selector are captured at the `start` edge, so later changes to them do not affect the result.
- R10: With `TWO_CYCLE = 1`, a `start` that arrives while a computation is in flight is ignored. It produces no further `done` and no change to `result`.
- R11: `result` changes only at an edge that sets `done`. Otherwise it holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a two-round step on the current operands |
| round_sel | input | 6 | Number of the first round; bit 0 is ignored |
| opnd_a | input | 128 | Unrotated C, D, G, H in lanes 3, 2, 1, 0 |
| opnd_b | input | 128 | A, B, E, F in lanes 3, 2, 1, 0 |
| opnd_c | input | 128 | Four message words for the two rounds |
| done | output | 1 | One-cycle pulse: `result` has just been updated |
| result | output | 128 | Updated A, B, E, F in lanes 3, 2, 1, 0 |

## Verification
The single-cycle build delivers its result one edge after `start`, and the per-round build delivers it two edges after `start`. The bench drives inputs on falling edges and reads both instances on the falling edge that follows each delivering edge. At that point it also confirms that the other build has not yet signalled. A further falling edge with no `start` checks that `done` has dropped and `result` has held. Round selectors on both sides of the round-16 change, and at the top of the range where the rotation amount wraps, are compared against a word-level model written in the bench.

// File: rtl/sm3_dual_round.sv
module sm3_dual_round #(
  parameter bit          TWO_CYCLE  = 1'b0,
  parameter int          WORD       = 32,
  parameter int          IDX_W      = 6,
  parameter int          SPLIT      = 16,
  parameter logic [31:0] T_LOW      = 32'h79CC4519,
  parameter logic [31:0] T_HIGH     = 32'h7A879D8A
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [5:0]   round_sel,
  input  logic [127:0] opnd_a,
  input  logic [127:0] opnd_b,
  input  logic [127:0] opnd_c,
  output logic         done,
  output logic [127:0] result
);
  localparam int LANES = 4;
  localparam int OPW   = WORD * LANES;
  localparam int STW   = WORD * 8;
  localparam int RW    = $clog2(WORD);

  function automatic logic [WORD-1:0] rotl(input logic [WORD-1:0] x, input logic [RW-1:0] n);
    return (x << n) | (x >> (WORD - int'(n)));
  endfunction

  function automatic logic [WORD-1:0] p0(input logic [WORD-1:0] x);
    return x ^ rotl(x, RW'(9)) ^ rotl(x, RW'(17));
  endfunction

  function automatic logic [STW-1:0] step(input logic [STW-1:0] s, input logic [IDX_W-1:0] r,
                                          input logic [WORD-1:0] w, input logic [WORD-1:0] wp);
    logic [WORD-1:0] a, b, c, d, e, f, g, h, t, a12, ss1, ss2, ff, gg, tt1, tt2;
    {a, b, c, d, e, f, g, h} = s;
    t   = (int'(r) < SPLIT) ? T_LOW : T_HIGH;
    a12 = rotl(a, RW'(12));
    ss1 = rotl(a12 + e + rotl(t, r[RW-1:0]), RW'(7));
    ss2 = ss1 ^ a12;
    if (int'(r) < SPLIT) begin
      ff = a ^ b ^ c;
      gg = e ^ f ^ g;
    end else begin
      ff = (a & b) | (a & c) | (b & c);
      gg = (e & f) | (~e & g);
    end
    tt1 = ff + d + ss2 + wp;
    tt2 = gg + h + ss1 + w;
    return {tt1, a, rotl(b, RW'(9)), c, p0(tt2), e, rotl(f, RW'(19)), g};
  endfunction

  function automatic logic [OPW-1:0] pack(input logic [STW-1:0] s);
    return {s[STW-1 -: WORD], s[STW-WORD-1 -: WORD], s[STW-4*WORD-1 -: WORD], s[STW-5*WORD-1 -: WORD]};
  endfunction

  logic [IDX_W-1:0] first_rnd;
  logic [STW-1:0]   entry;
  logic [WORD-1:0]  w0, wp0, w1, wp1;
  logic             busy;

  assign first_rnd = round_sel & 6'h3E;
  assign entry = {opnd_b[127:96], opnd_b[95:64],
                  rotl(opnd_a[127:96], RW'(9)),  rotl(opnd_a[95:64], RW'(9)),
                  opnd_b[63:32], opnd_b[31:0],
                  rotl(opnd_a[63:32], RW'(19)), rotl(opnd_a[31:0], RW'(19))};
  assign w0  = opnd_c[31:0];
  assign wp0 = opnd_c[31:0] ^ opnd_c[95:64];
  assign w1  = opnd_c[63:32];
  assign wp1 = opnd_c[63:32] ^ opnd_c[127:96];

  generate
    if (TWO_CYCLE) begin : g_seq
      logic [STW-1:0]   mid_q;
      logic [IDX_W-1:0] rnd_q;
      logic [WORD-1:0]  w_q, wp_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          mid_q  <= '0;
          rnd_q  <= '0;
          w_q    <= '0;
          wp_q   <= '0;
          busy   <= 1'b0;
          done   <= 1'b0;
          result <= '0;
        end else if (busy) begin
          result <= pack(step(mid_q, rnd_q, w_q, wp_q));
          done   <= 1'b1;
          busy   <= 1'b0;
        end else begin
          done <= 1'b0;
          if (start) begin
            mid_q <= step(entry, first_rnd, w0, wp0);
            rnd_q <= first_rnd | IDX_W'(1);
            w_q   <= w1;
            wp_q  <= wp1;
            busy  <= 1'b1;
          end
        end
      end
    end else begin : g_comb
      logic [STW-1:0] both;
      assign both = step(step(entry, first_rnd, w0, wp0), first_rnd | IDX_W'(1), w1, wp1);
      assign busy = 1'b0;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          done   <= 1'b0;
          result <= '0;
        end else begin
          done <= start;
          if (start) result <= pack(both);
        end
      end
    end
  endgenerate
endmodule

// File: rtl/sm3_dual_round_chk.sv
module sm3_dual_round_chk #(
  parameter bit TWO_CYCLE = 1'b0
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic [127:0] result
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) !rst_n |=> (!done && result == '0));

  // R11
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !done |-> $stable(result));

  generate
    if (TWO_CYCLE) begin : g_seq
      // R9
      seq_done_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> $past(busy));
      // R9
      seq_gap_chk: assert property (@(posedge clk) disable iff (!rst_n) (start && !busy) |=> (busy && !done));
      // R10
      busy_once_chk: assert property (@(posedge clk) disable iff (!rst_n) busy |=> !busy);
    end else begin : g_comb
      // R8
      fast_done_chk: assert property (@(posedge clk) disable iff (!rst_n) start |=> done);
      // R8
      fast_src_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> $past(start));
    end
  endgenerate
endmodule

bind sm3_dual_round sm3_dual_round_chk #(.TWO_CYCLE(TWO_CYCLE)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .result(result)
);

// File: tb/sm3_dual_round_bench.sv
module sm3_dual_round_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [5:0]   round_sel = '0;
  logic [127:0] opnd_a = '0, opnd_b = '0, opnd_c = '0;
  logic         done_f, done_s;
  logic [127:0] res_f, res_s;
  int           n_cmp = 0, n_bad = 0;
  bit           finished = 1'b0;

  always #2 clk = ~clk;

  sm3_dual_round #(.TWO_CYCLE(1'b0)) u_sm3_dual_round (
    .clk(clk), .rst_n(rst_n), .start(start), .round_sel(round_sel),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .opnd_c(opnd_c), .done(done_f), .result(res_f));

  sm3_dual_round #(.TWO_CYCLE(1'b1)) u_sm3_dual_round_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .round_sel(round_sel),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .opnd_c(opnd_c), .done(done_s), .result(res_s));

  function automatic logic [31:0] rl(input logic [31:0] x, input int n);
    logic [63:0] d;
    d = {x, x} << (n % 32);
    return d[63:32];
  endfunction

  function automatic logic [127:0] model(input logic [127:0] a, input logic [127:0] b,
                                         input logic [127:0] c, input int sel);
    logic [31:0] s [8];
    logic [31:0] al [4];
    logic [31:0] bl [4];
    logic [31:0] cl [4];
    logic [31:0] tc, x12, s1, s2, f1, g1, t1, t2;
    int j;
    for (int k = 0; k < 4; k++) begin
      al[k] = a[32*k +: 32];
      bl[k] = b[32*k +: 32];
      cl[k] = c[32*k +: 32];
    end
    j = sel & 62;
    s[0] = bl[3]; s[1] = bl[2]; s[2] = rl(al[3], 9);  s[3] = rl(al[2], 9);
    s[4] = bl[1]; s[5] = bl[0]; s[6] = rl(al[1], 19); s[7] = rl(al[0], 19);
    for (int i = 0; i < 2; i++) begin
      int r;
      r  = j + i;
      tc = (r < 16) ? 32'h79CC4519 : 32'h7A879D8A;
      x12 = rl(s[0], 12);
      s1 = rl(x12 + s[4] + rl(tc, r), 7);
      s2 = s1 ^ x12;
      f1 = (r < 16) ? (s[0] ^ s[1] ^ s[2]) : ((s[0] & s[1]) | (s[0] & s[2]) | (s[1] & s[2]));
      g1 = (r < 16) ? (s[4] ^ s[5] ^ s[6]) : ((s[4] & s[5]) | (~s[4] & s[6]));
      t1 = f1 + s[3] + s2 + (cl[i] ^ cl[i+2]);
      t2 = g1 + s[7] + s1 + cl[i];
      s[3] = s[2]; s[2] = rl(s[1], 9);  s[1] = s[0]; s[0] = t1;
      s[7] = s[6]; s[6] = rl(s[5], 19); s[5] = s[4]; s[4] = t2 ^ rl(t2, 9) ^ rl(t2, 17);
    end
    return {s[0], s[1], s[4], s[5]};
  endfunction

  task automatic cmp(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input int sel, input logic [127:0] a, input logic [127:0] b, input logic [127:0] c);
    round_sel = 6'(sel); opnd_a = a; opnd_b = b; opnd_c = c;
  endtask

  task automatic t_reset();
    cmp("R1 fast done", 128'(done_f), 128'(0));
    cmp("R1 fast result", res_f, '0);
    cmp("R1 seq done", 128'(done_s), 128'(0));
    cmp("R1 seq result", res_s, '0);
  endtask

  // One step through both builds: R3 R4 R5 R6 R7 contents, R8 R9 timing, R11 hold
  task automatic t_step(input string tag, input int sel,
                        input logic [127:0] a, input logic [127:0] b, input logic [127:0] c);
    logic [127:0] exp;
    exp = model(a, b, c, sel);
    @(negedge clk); apply(sel, a, b, c); start = 1'b1;
    @(negedge clk); start = 1'b0;
    cmp({tag, " R8 fast done"}, 128'(done_f), 128'(1));
    cmp({tag, " R3/R4/R5/R6/R7 fast result"}, res_f, exp);
    cmp({tag, " R9 seq not yet done"}, 128'(done_s), 128'(0));
    @(negedge clk);
    cmp({tag, " R9 seq done"}, 128'(done_s), 128'(1));
    cmp({tag, " R3/R4/R5/R6/R7 seq result"}, res_s, exp);
    cmp({tag, " R11 fast held"}, res_f, exp);
    cmp({tag, " R8 fast pulse"}, 128'(done_f), 128'(0));
  endtask

  // R2: odd selector must equal even neighbour
  task automatic t_odd(input int sel, input logic [127:0] a, input logic [127:0] b, input logic [127:0] c);
    logic [127:0] exp;
    exp = model(a, b, c, sel & 62);
    @(negedge clk); apply(sel, a, b, c); start = 1'b1;
    @(negedge clk); start = 1'b0;
    cmp("R2 fast odd selector", res_f, exp);
    @(negedge clk);
    cmp("R2 seq odd selector", res_s, exp);
  endtask

  // R9: operands change after the start edge
  task automatic t_capture();
    logic [127:0] exp;
    exp = model(128'h0123456789ABCDEF_FEDCBA9876543210, 128'h02468ACE13579BDF_FDB97531ECA86420,
                128'h048C159D26AE37BF_FB73EA62D951C840, 20);
    @(negedge clk);
    apply(20, 128'h0123456789ABCDEF_FEDCBA9876543210, 128'h02468ACE13579BDF_FDB97531ECA86420,
          128'h048C159D26AE37BF_FB73EA62D951C840);
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    apply(2, '1, 128'h5555AAAA_5555AAAA_3333CCCC_3333CCCC, 128'hDEADBEEF_0BADF00D_CAFEBABE_12345678);
    @(negedge clk);
    cmp("R9 seq captured operands", res_s, exp);
  endtask

  // R10/R8/R11: start while seq busy; fast build accepts back-to-back
  task automatic t_busy();
    logic [127:0] a1, b1, c1, a2, b2, c2, e1, e2;
    a1 = 128'h00112233_44556677_8899AABB_CCDDEEFF; b1 = 128'hFFEEDDCC_BBAA9988_77665544_33221100;
    c1 = 128'h01234567_89ABCDEF_FEDCBA98_76543210;
    a2 = 128'h13579BDF_02468ACE_ECA86420_FDB97531; b2 = 128'h89ABCDEF_01234567_76543210_FEDCBA98;
    c2 = 128'hA5A5A5A5_5A5A5A5A_0F0F0F0F_F0F0F0F0;
    e1 = model(a1, b1, c1, 10);
    e2 = model(a2, b2, c2, 40);
    @(negedge clk); apply(10, a1, b1, c1); start = 1'b1;
    @(negedge clk); apply(40, a2, b2, c2); start = 1'b1;
    @(negedge clk); start = 1'b0;
    cmp("R8 fast back-to-back result", res_f, e2);
    cmp("R8 fast back-to-back done", 128'(done_f), 128'(1));
    cmp("R10 seq finishes first job", res_s, e1);
    @(negedge clk);
    cmp("R10 seq no second done", 128'(done_s), 128'(0));
    cmp("R10 seq result unchanged", res_s, e1);
    @(negedge clk);
    cmp("R11 seq still held", res_s, e1);
    cmp("R11 fast still held", res_f, e2);
  endtask

  initial begin
    #100000;
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_step("r0 xor", 0, 128'h00112233_44556677_8899AABB_CCDDEEFF,
           128'hFFEEDDCC_BBAA9988_77665544_33221100, 128'h01234567_89ABCDEF_FEDCBA98_76543210);
    t_step("r14 below split", 14, 128'h33221100_77665544_BBAA9988_FFEEDDCC,
           128'h76543210_FEDCBA98_89ABCDEF_01234567, 128'hECA86420_FDB97531_13579BDF_02468ACE);
    t_step("r16 at split", 16, 128'h33221100_77665544_BBAA9988_FFEEDDCC,
           128'h76543210_FEDCBA98_89ABCDEF_01234567, 128'hECA86420_FDB97531_13579BDF_02468ACE);
    t_step("r30 above split", 30, 128'h33221100_77665544_BBAA9988_FFEEDDCC,
           128'h76543210_FEDCBA98_89ABCDEF_01234567, 128'hECA86420_FDB97531_13579BDF_02468ACE);
    t_step("r62 rotation wrap", 62, 128'hCAFEBABE_DEADBEEF_0BADF00D_12345678,
           128'h0F1E2D3C_4B5A6978_8796A5B4_C3D2E1F0, 128'h11111111_22222222_44444444_88888888);
    t_step("r32 zero ops", 32, '0, '0, '0);
    t_step("r8 all ones", 8, '1, '1, '1);
    t_odd(31, 128'h33221100_77665544_BBAA9988_FFEEDDCC,
          128'h76543210_FEDCBA98_89ABCDEF_01234567, 128'hECA86420_FDB97531_13579BDF_02468ACE);
    t_odd(63, 128'hCAFEBABE_DEADBEEF_0BADF00D_12345678,
          128'h0F1E2D3C_4B5A6978_8796A5B4_C3D2E1F0, 128'h11111111_22222222_44444444_88888888);
    t_capture();
    t_busy();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule